// File: doc/BRIEF.md
# Flash Status Poll Engine

This block waits on a serial flash device without software involvement. When started, it asks an attached command phase engine to send a status-read instruction. For a typical device this is opcode 0x05, with the instruction and the data each on a single line, no address and no dummy cycles. The engine returns one status byte per read. The block compares that byte with a captured mask and match value. If they agree, the block stops and raises a match flag. If they do not agree, it idles for a programmed number of cycles and then issues the read again.

An optional cycle budget ends the wait with a timeout flag when no agreeing byte arrives. The last byte received stays visible after either outcome.

There are two typical uses. To wait for the device to become ready, use mask 0x01 and match 0x00; status bit 0 is the busy bit. To wait for the write-enable latch, use mask 0x02 and match 0x02; status bit 1 is that latch. Reads are usually separated by 16 idle cycles.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, busy, cmd_valid, match_hit and timed_out are 0, and last_status is 0x00.
- R2: A start pulse while idle captures opcode, mask, match, interval and limit. In the next cycle, busy and cmd_valid are 1, cmd_opcode equals the captured opcode, and match_hit and timed_out are cleared.
- R3: cmd_valid stays high until a cycle with cmd_ready high. After that handshake, cmd_valid is low while the block waits for rsp_valid.
- R4: A response hits when ((rsp_data XOR match) AND mask) is zero, using the captured mask and match. On a hit, in the next cycle last_status equals rsp_data, busy is 0 and match_hit is 1.
- R5: On a response that does not hit, last_status takes rsp_data. cmd_valid then stays low for exactly `interval` cycles before the same opcode is requested again. An interval of 0 reissues in the very next cycle.
- R6: While busy, changes on opcode, mask, match, interval and limit have no effect, and start is ignored.
- R7: With limit L not equal to 0 and no hit, busy stays high for exactly L cycles after the start cycle. It then drops with timed_out 1 and match_hit 0, and last_status keeps the last byte received.
- R8: A limit of 0 disables the timeout; polling continues until a hit.
- R9: If a hitting response arrives in the same cycle the limit expires, the hit wins: match_hit is 1 and timed_out is 0.
- R10: rsp_valid is ignored unless a response is awaited; last_status does not change.
- R11: match_hit and timed_out hold their values while idle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (sampled only while idle) |
| opcode | input | 8 | Status-read instruction to request |
| mask | input | 8 | Bits of the status byte that are compared |
| match_val | input | 8 | Expected values of the masked bits |
| interval | input | 16 | Idle cycles between a miss and the next read |
| limit | input | 24 | Busy cycles before timeout; 0 disables |
| cmd_valid | output | 1 | Request to the command phase engine |
| cmd_opcode | output | 8 | Instruction for the request |
| cmd_ready | input | 1 | Engine accepts the request |
| rsp_valid | input | 1 | Status byte returned |
| rsp_data | input | 8 | Returned status byte |
| busy | output | 1 | Polling in progress |
| match_hit | output | 1 | Polling ended on a hit |
| timed_out | output | 1 | Polling ended on limit expiry |
| last_status | output | 8 | Most recent accepted status byte |

## Verification
Two events can land on the same edge: a response being judged, and the cycle budget running out. The bench provokes this by starting with a limit of 2, accepting the request at once, and returning the status byte so that it is sampled on exactly the second busy edge. It then checks that a hitting byte yields match_hit without timed_out, and that a missing byte yields timed_out with last_status still updated. A limit of 3 with a miss shows expiry landing during the idle gap instead.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_GAP   = 2'd3
    } poll_state_e;

    // Status bit positions used by the common wait conditions
    localparam int unsigned STS_BUSY_BIT = 0;
    localparam int unsigned STS_WEL_BIT  = 1;

endpackage

// File: rtl/poll_match_cmp.sv
module poll_match_cmp #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] status,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] expect_val,
    output logic          hit
);
    logic [DW-1:0] diff;

    always_comb begin
        diff = (status ^ expect_val) & mask;
        hit  = (diff == '0);
    end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int unsigned TW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && (cnt_q != '1)) begin
            cnt_d = cnt_q + TW'(1);
        end
        expire = run && (limit != '0) && (cnt_q == (limit - TW'(1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
    import poll_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned GW = 16,
    parameter int unsigned TW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] opcode,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] match_val,
    input  logic [GW-1:0] interval,
    input  logic [TW-1:0] limit,
    output logic          cmd_valid,
    output logic [DW-1:0] cmd_opcode,
    input  logic          cmd_ready,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    output logic          busy,
    output logic          match_hit,
    output logic          timed_out,
    output logic [DW-1:0] last_status
);
    typedef struct packed {
        poll_state_e   st;
        logic [DW-1:0] op;
        logic [DW-1:0] msk;
        logic [DW-1:0] mval;
        logic [GW-1:0] gap_ld;
        logic [GW-1:0] gap_cnt;
        logic [TW-1:0] lim;
        logic          hit_f;
        logic          tmo_f;
        logic [DW-1:0] last;
    } regs_t;

    regs_t r_d, r_q;
    logic  cmp_hit;
    logic  tmo_expire;
    logic  accept_rsp;

    poll_match_cmp #(.DW(DW)) cmp_i (
        .status     (rsp_data),
        .mask       (r_q.msk),
        .expect_val (r_q.mval),
        .hit        (cmp_hit)
    );

    poll_timer #(.TW(TW)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (r_q.st == ST_IDLE),
        .run    (r_q.st != ST_IDLE),
        .limit  (r_q.lim),
        .expire (tmo_expire)
    );

    always_comb begin
        r_d        = r_q;
        accept_rsp = (r_q.st == ST_WAIT) && rsp_valid;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_ISSUE;
                    r_d.op     = opcode;
                    r_d.msk    = mask;
                    r_d.mval   = match_val;
                    r_d.gap_ld = interval;
                    r_d.lim    = limit;
                    r_d.hit_f  = 1'b0;
                    r_d.tmo_f  = 1'b0;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    r_d.last = rsp_data;
                    if (cmp_hit) begin
                        r_d.st    = ST_IDLE;
                        r_d.hit_f = 1'b1;
                    end else if (r_q.gap_ld == '0) begin
                        r_d.st = ST_ISSUE;
                    end else begin
                        r_d.st      = ST_GAP;
                        r_d.gap_cnt = r_q.gap_ld;
                    end
                end
            end
            ST_GAP: begin
                if (r_q.gap_cnt <= GW'(1)) r_d.st = ST_ISSUE;
                else                       r_d.gap_cnt = r_q.gap_cnt - GW'(1);
            end
            default: r_d.st = ST_IDLE;
        endcase
        // Budget expiry loses to a hit judged on the same edge
        if (tmo_expire && !(accept_rsp && cmp_hit)) begin
            r_d.st    = ST_IDLE;
            r_d.tmo_f = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign cmd_valid   = (r_q.st == ST_ISSUE);
    assign cmd_opcode  = r_q.op;
    assign match_hit   = r_q.hit_f;
    assign timed_out   = r_q.tmo_f;
    assign last_status = r_q.last;
endmodule

// File: rtl/flash_status_poller_chk.sv
module flash_status_poller_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [DW-1:0] cmd_opcode,
    input logic          rsp_valid,
    input logic          busy,
    input logic          match_hit,
    input logic          timed_out,
    input logic [DW-1:0] last_status
);
    p_idle_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);

    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!match_hit && !timed_out));

    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid || !busy));

    p_end_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (match_hit || timed_out));

    p_opcode_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_opcode));

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_hit && timed_out));

    p_last_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> $stable(last_status));
endmodule

bind flash_status_poller flash_status_poller_chk #(.DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_opcode  (cmd_opcode),
    .rsp_valid   (rsp_valid),
    .busy        (busy),
    .match_hit   (match_hit),
    .timed_out   (timed_out),
    .last_status (last_status)
);

// File: tb/flash_status_poller_tb_top.sv
module flash_status_poller_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  mask = 8'h00;
    logic [7:0]  match_val = 8'h00;
    logic [15:0] interval = 16'h0;
    logic [23:0] limit = 24'h0;
    logic        cmd_valid;
    logic [7:0]  cmd_opcode;
    logic        cmd_ready = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_data = 8'h00;
    logic        busy, match_hit, timed_out;
    logic [7:0]  last_status;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    flash_status_poller dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .mask(mask),
        .match_val(match_val), .interval(interval), .limit(limit),
        .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
        .match_hit(match_hit), .timed_out(timed_out), .last_status(last_status)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic bit exp_hit(input [7:0] s, input [7:0] m, input [7:0] v);
        return ((s & m) == (v & m));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Start polling; with scramble set, disturb the inputs and re-pulse start while busy (R6)
    task automatic begin_poll(input [7:0] op, input [7:0] m, input [7:0] v,
                              input [15:0] gap, input [23:0] lim, input bit scramble);
        @(negedge clk);
        start = 1'b1; opcode = op; mask = m; match_val = v; interval = gap; limit = lim;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy", busy, 1);
        chk(cmd_valid == 1'b1, "R2 cmd_valid", cmd_valid, 1);
        chk(cmd_opcode == op, "R2 opcode", cmd_opcode, op);
        chk(!match_hit && !timed_out, "R2 flags clear", {match_hit, timed_out}, 0);
        if (scramble) begin
            start = 1'b1; opcode = ~op; mask = 8'($urandom); match_val = 8'($urandom);
            interval = 16'($urandom_range(0, 9)); limit = 24'd1;
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    // Serve one request, cmd_valid is high on entry
    task automatic serve(input [7:0] s, input int rdy_dly, input int rsp_dly);
        for (int d = 0; d < rdy_dly; d++) begin
            chk(cmd_valid == 1'b1, "R3 held", cmd_valid, 1);
            @(negedge clk);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        chk(cmd_valid == 1'b0, "R3 waiting", cmd_valid, 0);
        for (int d = 0; d < rsp_dly; d++) @(negedge clk);
        rsp_valid = 1'b1; rsp_data = s;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(last_status == s, "R4/R5 last_status", last_status, s);
    endtask

    task automatic after_miss(input [7:0] op, input [15:0] gap);
        int cnt = 0;
        chk(busy == 1'b1, "R5 still busy", busy, 1);
        while (!cmd_valid && cnt < 200) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == int'(gap), "R5 gap length", cnt, gap);
        chk(cmd_opcode == op, "R6 opcode kept", cmd_opcode, op);
    endtask

    task automatic after_hit();
        chk(busy == 1'b0, "R4 stopped", busy, 0);
        chk(match_hit == 1'b1 && timed_out == 1'b0, "R4 match flag", {match_hit, timed_out}, 2);
    endtask

    task automatic directed_seq(input [7:0] m, input [7:0] v, input [7:0] s0,
                                input [7:0] s1, input [7:0] s2);
        begin_poll(8'h05, m, v, 16'h10, 24'd0, 1'b0);
        serve(s0, 1, 0); chk(!exp_hit(s0, m, v), "R5 directed miss", s0, 0); after_miss(8'h05, 16'h10);
        serve(s1, 0, 2); after_miss(8'h05, 16'h10);
        serve(s2, 2, 1); after_hit();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && !cmd_valid && !match_hit && !timed_out, "R1 reset outputs",
            {busy, cmd_valid, match_hit, timed_out}, 0);
        chk(last_status == 8'h00, "R1 reset last_status", last_status, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Wait-for-ready: busy bit 0 must clear
        directed_seq(8'h01, 8'h00, 8'h03, 8'h01, 8'h02);
        // R11 flags persist, R10 response while idle ignored
        rsp_valid = 1'b1; rsp_data = 8'h55;
        @(negedge clk);
        rsp_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(match_hit == 1'b1 && !timed_out, "R11 flags hold", {match_hit, timed_out}, 2);
        chk(last_status == 8'h02, "R10 idle rsp ignored", last_status, 8'h02);

        // Wait-for-write-enable: bit 1 must set
        directed_seq(8'h02, 8'h02, 8'h00, 8'h01, 8'h03);

        // R10: response while a request is still pending is ignored
        begin_poll(8'h05, 8'h01, 8'h00, 16'd0, 24'd0, 1'b0);
        rsp_valid = 1'b1; rsp_data = 8'hAA;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(last_status == 8'h03, "R10 pending rsp ignored", last_status, 8'h03);
        chk(cmd_valid == 1'b1, "R10 still requesting", cmd_valid, 1);
        serve(8'h00, 0, 0); after_hit();

        // R7: no handshake at all, limit 7
        begin
            int bc = 1;
            begin_poll(8'h05, 8'h01, 8'h00, 16'd4, 24'd7, 1'b0);
            while (busy && bc < 100) begin
                @(negedge clk);
                if (busy) bc++;
            end
            chk(bc == 7, "R7 busy length", bc, 7);
            chk(timed_out == 1'b1 && match_hit == 1'b0, "R7 timeout flag", {match_hit, timed_out}, 1);
            chk(last_status == 8'h00, "R7 last kept", last_status, 0);
            repeat (3) @(negedge clk);
            chk(timed_out == 1'b1, "R11 timeout holds", timed_out, 1);
        end

        // R9: response judged on the expiry edge
        begin_poll(8'h05, 8'h01, 8'h00, 16'd3, 24'd2, 1'b0);
        cmd_ready = 1'b1; @(negedge clk); cmd_ready = 1'b0;
        rsp_valid = 1'b1; rsp_data = 8'h10; @(negedge clk); rsp_valid = 1'b0;
        chk(!busy && match_hit && !timed_out, "R9 hit wins", {busy, match_hit, timed_out}, 2);

        begin_poll(8'h05, 8'h01, 8'h00, 16'd3, 24'd2, 1'b0);
        cmd_ready = 1'b1; @(negedge clk); cmd_ready = 1'b0;
        rsp_valid = 1'b1; rsp_data = 8'h21; @(negedge clk); rsp_valid = 1'b0;
        chk(!busy && !match_hit && timed_out, "R9 miss times out", {busy, match_hit, timed_out}, 1);
        chk(last_status == 8'h21, "R7 last on expiry", last_status, 8'h21);

        begin_poll(8'h05, 8'h01, 8'h00, 16'd3, 24'd3, 1'b0);
        cmd_ready = 1'b1; @(negedge clk); cmd_ready = 1'b0;
        rsp_valid = 1'b1; rsp_data = 8'h01; @(negedge clk); rsp_valid = 1'b0;
        chk(busy == 1'b1, "R7 in gap", busy, 1);
        @(negedge clk);
        chk(!busy && timed_out, "R7 expiry in gap", {busy, timed_out}, 1);

        // R8: limit 0 never expires
        begin_poll(8'h05, 8'h01, 8'h00, 16'd0, 24'd0, 1'b0);
        repeat (300) @(negedge clk);
        chk(busy && cmd_valid && !timed_out, "R8 no expiry", {busy, cmd_valid, timed_out}, 6);
        serve(8'hFE, 0, 0); after_hit();

        // Random runs with scrambled inputs while busy
        for (int it = 0; it < 40; it++) begin
            logic [7:0] op, m, v, s;
            logic [15:0] gap;
            int np;
            op = 8'($urandom); m = 8'($urandom); v = 8'($urandom);
            gap = 16'($urandom_range(0, 5));
            np = (m == 8'h00) ? 1 : $urandom_range(1, 6);
            begin_poll(op, m, v, gap, (it % 2 == 0) ? 24'd0 : 24'd5000, 1'b1);
            for (int p = 0; p < np; p++) begin
                if (p == np - 1) begin
                    s = (8'($urandom) & ~m) | (v & m);
                end else begin
                    s = 8'($urandom);
                    if (exp_hit(s, m, v)) s = s ^ (m & (~m + 8'd1));
                end
                serve(s, $urandom_range(0, 2), $urandom_range(0, 2));
                if (exp_hit(s, m, v)) after_hit();
                else                  after_miss(op, gap);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule